// File: doc/BRIEF.md
# Real-Mode Segment Fault Classifier

This block sits beside the address path of a 16-bit segmented real-mode core. For every memory request or interrupt dispatch the core hands it, the block decides whether the request must trap. If it must, the block names the exception vector to raise. Memory requests carry an access kind (instruction fetch, data or stack), a segment selector code, a 16-bit offset and an operand size. Interrupt dispatches carry the vector number and the current limit of the interrupt table instead.

A request is accepted on a valid/ready handshake. One clock later the block presents a single-cycle registered result. The result holds a fault flag, the exception vector and a restart flag. The restart flag says the saved return address must point at the start of the faulting instruction.

There are three fault checks, taken in priority order:
- A stack access that runs past the end of its 64K segment gets its own vector.
- An access through any other segment, or a fetch, that wraps the 64K boundary shares a second vector.
- A dispatch whose 4-byte table entry lies beyond the table limit reports a third vector.

The controller has two states. ST_IDLE holds the ready signal high; the transition ACCEPT (request valid while idle) moves it to ST_REPORT. ST_REPORT drives the result valid for one cycle; the transition RETIRE always returns it to ST_IDLE.

Top module: `rm_fault_classifier`

## Requirements
- R1: `req_ready` is high only in ST_IDLE. A request accepted at a clock edge produces `out_valid` high for exactly the following cycle, and `req_ready` is low during that cycle.
- R2: A dispatch (`req_kind` = 3) whose vector times 4 plus 3 exceeds `req_tbl_limit` reports a fault with vector 8.
- R3: A dispatch whose vector times 4 plus 3 is less than or equal to `req_tbl_limit` reports no fault, including the case where the two are equal.
- R4: A data access (`req_kind` = 1) through any segment code other than SS (code 2) faults with vector 13 when offset plus `req_size` exceeds 0xFFFF. `req_size` is the byte count minus one.
- R5: A data access whose last byte lands at or below 0xFFFF does not fault; in particular a byte access at offset 0xFFFF does not fault.
- R6: A fetch (`req_kind` = 0) faults with vector 13 when offset plus `req_size` exceeds 0xFFFF, whatever the segment code.
- R7: A stack access (`req_kind` = 2), or a data access through SS (code 2), faults with vector 12 when it crosses 0xFFFF; vector 12 takes precedence over vector 13.
- R8: Every fault result has `out_restart` high. A non-fault result has `out_fault`, `out_restart` and `out_vector` all zero.
- R9: The reported vector is never 10, 11 or 14.
- R10: After reset `req_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 fetch, 1 data, 2 stack, 3 interrupt dispatch |
| req_seg | input | 3 | Segment code: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| req_offset | input | 16 | Offset within the segment |
| req_size | input | 2 | Operand byte count minus one |
| req_vec | input | 8 | Interrupt vector for a dispatch |
| req_tbl_limit | input | 16 | Current interrupt-table limit in bytes |
| out_valid | output | 1 | Result present for one cycle |
| out_fault | output | 1 | Request raises an exception |
| out_vector | output | 8 | Exception vector number |
| out_restart | output | 1 | Return address is the faulting instruction |

## Verification
The bench builds the block with its default parameters: 16-bit offsets and limits, 8-bit vectors, and a 2-bit size field that covers accesses of up to four bytes. These widths put every wrap point within direct reach. The bench steps a word and a dword across the last offsets of a segment, one byte short of the wrap, exactly at it and one byte past it. It places the table limit exactly on, and one byte below, the last byte of the lowest and the highest vector entries. It also exercises the SS-over-general precedence and a fetch that carries a stray segment code.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

    typedef enum logic [1:0] {
        K_FETCH    = 2'd0,
        K_DATA     = 2'd1,
        K_STACK    = 2'd2,
        K_DISPATCH = 2'd3
    } acc_kind_e;

    localparam logic [2:0] SEG_ES = 3'd0;
    localparam logic [2:0] SEG_CS = 3'd1;
    localparam logic [2:0] SEG_SS = 3'd2;
    localparam logic [2:0] SEG_DS = 3'd3;
    localparam logic [2:0] SEG_FS = 3'd4;
    localparam logic [2:0] SEG_GS = 3'd5;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/rmf_span_check.sv
module rmf_span_check #(
    parameter int OFS_W = 16,
    parameter int SZ_W  = 2
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [SZ_W-1:0]  size_m1,
    output logic             overrun
);
    localparam int SUM_W = OFS_W + 1;

    logic [SUM_W-1:0] last_byte;

    // Address of the final byte touched; a carry out means a segment wrap.
    assign last_byte = {1'b0, offset} + SUM_W'(size_m1);
    assign overrun   = last_byte[OFS_W];

endmodule

// File: rtl/rmf_table_check.sv
module rmf_table_check #(
    parameter int VEC_W       = 8,
    parameter int LIM_W       = 16,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [VEC_W-1:0] vector,
    input  logic [LIM_W-1:0] limit,
    output logic             out_of_range
);
    localparam int TOP_W = VEC_W + ENTRY_SHIFT;
    localparam int CMP_W = (TOP_W > LIM_W) ? TOP_W : LIM_W;

    logic [TOP_W-1:0] entry_last;
    logic [CMP_W-1:0] entry_cmp;
    logic [CMP_W-1:0] limit_cmp;

    // Last byte of the entry: vector * entry size + (entry size - 1).
    assign entry_last   = {vector, {ENTRY_SHIFT{1'b1}}};
    assign entry_cmp    = CMP_W'(entry_last);
    assign limit_cmp    = CMP_W'(limit);
    assign out_of_range = entry_cmp > limit_cmp;

endmodule

// File: rtl/rmf_priority.sv
module rmf_priority
    import rmf_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int VEC_TABLE = 8,
    parameter int VEC_STACK = 12,
    parameter int VEC_SEG   = 13
) (
    input  logic [1:0]       kind,
    input  logic [2:0]       seg,
    input  logic             span_over,
    input  logic             table_over,
    output logic             fault,
    output logic [VEC_W-1:0] vector
);
    logic stack_class;

    always_comb begin
        stack_class = 1'b0;
        fault       = 1'b0;
        vector      = '0;
        unique case (acc_kind_e'(kind))
            K_FETCH: begin
                if (span_over) begin
                    fault  = 1'b1;
                    vector = VEC_W'(VEC_SEG);
                end
            end
            K_DATA: begin
                stack_class = (seg == SEG_SS);
                if (span_over) begin
                    fault  = 1'b1;
                    vector = stack_class ? VEC_W'(VEC_STACK) : VEC_W'(VEC_SEG);
                end
            end
            K_STACK: begin
                stack_class = 1'b1;
                if (span_over) begin
                    fault  = 1'b1;
                    vector = VEC_W'(VEC_STACK);
                end
            end
            K_DISPATCH: begin
                if (table_over) begin
                    fault  = 1'b1;
                    vector = VEC_W'(VEC_TABLE);
                end
            end
        endcase
    end

endmodule

// File: rtl/rm_fault_classifier.sv
module rm_fault_classifier
    import rmf_pkg::*;
#(
    parameter int OFS_W       = 16,
    parameter int SZ_W        = 2,
    parameter int VEC_W       = 8,
    parameter int LIM_W       = 16,
    parameter int ENTRY_SHIFT = 2,
    parameter int VEC_TABLE   = 8,
    parameter int VEC_STACK   = 12,
    parameter int VEC_SEG     = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [2:0]       req_seg,
    input  logic [OFS_W-1:0] req_offset,
    input  logic [SZ_W-1:0]  req_size,
    input  logic [VEC_W-1:0] req_vec,
    input  logic [LIM_W-1:0] req_tbl_limit,
    output logic             out_valid,
    output logic             out_fault,
    output logic [VEC_W-1:0] out_vector,
    output logic             out_restart
);
    ctl_state_e       state_q, state_d;
    logic             accept;
    logic             span_over;
    logic             table_over;
    logic             cls_fault;
    logic [VEC_W-1:0] cls_vector;
    logic             fault_q;
    logic [VEC_W-1:0] vector_q;

    rmf_span_check #(.OFS_W(OFS_W), .SZ_W(SZ_W)) u_span (
        .offset  (req_offset),
        .size_m1 (req_size),
        .overrun (span_over)
    );

    rmf_table_check #(.VEC_W(VEC_W), .LIM_W(LIM_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_table (
        .vector       (req_vec),
        .limit        (req_tbl_limit),
        .out_of_range (table_over)
    );

    rmf_priority #(
        .VEC_W(VEC_W), .VEC_TABLE(VEC_TABLE), .VEC_STACK(VEC_STACK), .VEC_SEG(VEC_SEG)
    ) u_prio (
        .kind       (req_kind),
        .seg        (req_seg),
        .span_over  (span_over),
        .table_over (table_over),
        .fault      (cls_fault),
        .vector     (cls_vector)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // Next-state logic: ACCEPT and RETIRE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result register, loaded on ACCEPT.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q  <= 1'b0;
            vector_q <= '0;
        end else if (accept) begin
            fault_q  <= cls_fault;
            vector_q <= cls_vector;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        req_ready   = 1'b0;
        out_valid   = 1'b0;
        out_fault   = 1'b0;
        out_vector  = '0;
        out_restart = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_REPORT: begin
                out_valid   = 1'b1;
                out_fault   = fault_q;
                out_vector  = vector_q;
                out_restart = fault_q;
            end
        endcase
    end

endmodule

// File: rtl/rmf_fault_checker.sv
module rmf_fault_checker #(
    parameter int VEC_W     = 8,
    parameter int VEC_TABLE = 8,
    parameter int VEC_STACK = 12,
    parameter int VEC_SEG   = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_kind,
    input logic             out_valid,
    input logic             out_fault,
    input logic [VEC_W-1:0] out_vector,
    input logic             out_restart
);
    p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    p_accept_reports_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> out_valid);

    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_dispatch_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault && $past(req_kind) == 2'd3) |-> out_vector == VEC_W'(VEC_TABLE));

    p_fetch_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault && $past(req_kind) == 2'd0) |-> out_vector == VEC_W'(VEC_SEG));

    p_stack_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault && $past(req_kind) == 2'd2) |-> out_vector == VEC_W'(VEC_STACK));

    p_fault_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> out_restart);

    p_clean_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fault) |-> (!out_restart && out_vector == '0));

    p_no_reserved_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_vector != VEC_W'(10) && out_vector != VEC_W'(11) && out_vector != VEC_W'(14)));

    always_comb begin
        if (!rst_n) begin
            p_reset_idle_r10: assert (req_ready && !out_valid);
        end
    end

endmodule

bind rm_fault_classifier rmf_fault_checker #(
    .VEC_W(VEC_W), .VEC_TABLE(VEC_TABLE), .VEC_STACK(VEC_STACK), .VEC_SEG(VEC_SEG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_kind    (req_kind),
    .out_valid   (out_valid),
    .out_fault   (out_fault),
    .out_vector  (out_vector),
    .out_restart (out_restart)
);

// File: tb/rm_fault_classifier_tb.sv
module rm_fault_classifier_tb;

    typedef struct {
        logic       fault;
        logic [7:0] vector;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_seg = '0;
    logic [15:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic [7:0]  req_vec = '0;
    logic [15:0] req_tbl_limit = '0;
    logic        out_valid;
    logic        out_fault;
    logic [7:0]  out_vector;
    logic        out_restart;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   n_sent   = 0;
    int   n_seen   = 0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    rm_fault_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_seg(req_seg), .req_offset(req_offset),
        .req_size(req_size), .req_vec(req_vec), .req_tbl_limit(req_tbl_limit),
        .out_valid(out_valid), .out_fault(out_fault), .out_vector(out_vector),
        .out_restart(out_restart)
    );

    task automatic push_req(input logic [1:0] kind, input logic [2:0] seg,
                            input logic [15:0] ofs, input logic [1:0] sz,
                            input logic [7:0] vec, input logic [15:0] lim,
                            input logic e_fault, input logic [7:0] e_vec, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_kind = kind; req_seg = seg; req_offset = ofs; req_size = sz;
        req_vec = vec; req_tbl_limit = lim; req_valid = 1'b1;
        e.fault = e_fault; e.vector = e_vec; e.tag = tag;
        sb_q.push_back(e);
        n_sent++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            n_seen++;
            n_checks++;
            if (req_ready) begin
                n_fail++;
                $display("FAIL R1 ready during report: actual=%0b expected=0", req_ready);
            end
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected result: actual=1 expected=0");
            end else begin
                e = sb_q.pop_front();
                n_checks++;
                if (out_fault !== e.fault || out_vector !== e.vector ||
                    out_restart !== e.fault) begin
                    n_fail++;
                    $display("FAIL %s/R8 actual=f%0b v%0d r%0b expected=f%0b v%0d r%0b",
                             e.tag, out_fault, out_vector, out_restart,
                             e.fault, e.vector, e.fault);
                end
                n_checks++;
                if (out_vector == 8'd10 || out_vector == 8'd11 || out_vector == 8'd14) begin
                    n_fail++;
                    $display("FAIL R9 reserved vector: actual=%0d expected=not 10/11/14", out_vector);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: idle state during reset
        n_checks++;
        if (req_ready !== 1'b1 || out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 actual=rdy%0b val%0b expected=rdy1 val0", req_ready, out_valid);
        end
        rst_n = 1'b1;

        // Interrupt dispatch limits
        push_req(2'd3, 3'd0, 16'h0, 2'd0, 8'd0,   16'h0003, 1'b0, 8'd0, "R3");
        push_req(2'd3, 3'd0, 16'h0, 2'd0, 8'd0,   16'h0002, 1'b1, 8'd8, "R2");
        push_req(2'd3, 3'd0, 16'h0, 2'd0, 8'd255, 16'h03FF, 1'b0, 8'd0, "R3");
        push_req(2'd3, 3'd0, 16'h0, 2'd0, 8'd255, 16'h03FE, 1'b1, 8'd8, "R2");
        push_req(2'd3, 3'd0, 16'h0, 2'd0, 8'd4,   16'h0013, 1'b0, 8'd0, "R3");
        push_req(2'd3, 3'd0, 16'h0, 2'd0, 8'd5,   16'h0013, 1'b1, 8'd8, "R2");

        // Data through general segments
        push_req(2'd1, 3'd3, 16'hFFFF, 2'd1, 8'd0, 16'h0, 1'b1, 8'd13, "R4");
        push_req(2'd1, 3'd4, 16'hFFFD, 2'd3, 8'd0, 16'h0, 1'b1, 8'd13, "R4");
        push_req(2'd1, 3'd0, 16'hFFFE, 2'd1, 8'd0, 16'h0, 1'b0, 8'd0,  "R5");
        push_req(2'd1, 3'd5, 16'hFFFF, 2'd0, 8'd0, 16'h0, 1'b0, 8'd0,  "R5");
        push_req(2'd1, 3'd1, 16'hFFFC, 2'd3, 8'd0, 16'h0, 1'b0, 8'd0,  "R5");

        // Fetches, segment code ignored
        push_req(2'd0, 3'd2, 16'hFFFF, 2'd1, 8'd0, 16'h0, 1'b1, 8'd13, "R6");
        push_req(2'd0, 3'd1, 16'hFFFE, 2'd3, 8'd0, 16'h0, 1'b1, 8'd13, "R6");
        push_req(2'd0, 3'd1, 16'hFFFF, 2'd0, 8'd0, 16'h0, 1'b0, 8'd0,  "R6");

        // Stack and SS precedence
        push_req(2'd2, 3'd2, 16'hFFFF, 2'd1, 8'd0, 16'h0, 1'b1, 8'd12, "R7");
        push_req(2'd1, 3'd2, 16'hFFFE, 2'd3, 8'd0, 16'h0, 1'b1, 8'd12, "R7");
        push_req(2'd2, 3'd2, 16'h0000, 2'd1, 8'd0, 16'h0, 1'b0, 8'd0,  "R7");
        push_req(2'd2, 3'd0, 16'hFFFC, 2'd3, 8'd0, 16'h0, 1'b0, 8'd0,  "R7");

        repeat (4) @(negedge clk);
        // R1: one result per accepted request
        n_checks++;
        if (n_seen != n_sent || sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 result count: actual=%0d expected=%0d", n_seen, n_sent);
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule